// File: doc/BRIEF.md
# Power-of-Two Block Allocator

This block hands out and takes back pieces of a pool of 2^K equal minimum-size blocks. Every piece it grants is a power-of-two number of blocks whose base is a multiple of that size. A request names an order `o` and asks for 2^o blocks. The allocator finds a free region of that order, splitting larger free regions into halves on the way down. It then returns the index of the region's first block. A release names a base and an order. When both halves of a pair become free again, they fuse back into their parent.

The pool is a complete binary tree with one node per possible region. Each node holds a small value: the order of the largest free region in its subtree, plus one, with zero meaning nothing is free. It also holds a flag that marks the node as a granted region. A search starts at the root and takes one tree level per clock. It prefers the lower-address half whenever that half can hold the request. After any change, the node values are rebuilt on the way back up to the root, also one level per clock.

Requests use a valid/ready handshake and are accepted only while the block is idle. Each accepted request produces exactly one single-cycle response. The response reports the granted base, a fail flag for an allocation that cannot be met, or an error flag for an illegal release.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, and after a reset that lands in the middle of an operation, the whole pool is free, `req_ready` is 1 and `rsp_valid` is 0. A following allocation of order K returns base 0.
- R2: An allocation of order o (o ≤ K) that can be met returns `rsp_fail`=0, `rsp_err`=0 and a base that is a multiple of 2^o. The base is the lowest-addressed free aligned region of that order, because the search always takes the lower half when that half can hold the request.
- R3: An allocation whose order exceeds K, or for which no free aligned region of that order exists, returns `rsp_fail`=1 and `rsp_err`=0. It changes no allocator state.
- R4: Releasing a region that is currently granted with exactly that base and order returns both flags 0 and makes the region free. When its paired half is also free, the two merge, recursively up to the whole pool.
- R5: A release whose order exceeds K, whose base is not a multiple of 2^order, or whose base/order is not a currently granted region returns `rsp_err`=1 and `rsp_fail`=0. It changes no allocator state.
- R6: `req_ready` is 1 only while idle. Each accepted request yields exactly one `rsp_valid` pulse, and `rsp_valid` is never raised without a preceding accepted request.
- R7: `rsp_fail` and `rsp_err` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_free | input | 1 | 1 = release, 0 = allocate |
| req_order | input | $clog2(K+2) | Size order of the region (2^order blocks) |
| req_base | input | K | Base block index, used by releases only |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fail | output | 1 | Allocation could not be met |
| rsp_err | output | 1 | Release was illegal |
| rsp_base | output | K | Granted base for an allocation; echoed base for a release |

## Verification
The hardest state to reach is the one where one region is fully fragmented into mixed granted and free pieces. Releasing the pieces in that state must make the fusions cascade through several levels. The stimulus first fills the pool with regions of every order, so that a single order-0 block sits beside an order-0 hole. It then releases them in a scrambled order, with illegal releases of the same bases in between. Finally it shows the fused result at the ports: one allocation of the whole pool returns base 0, and the next allocation fails.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DESC  = 2'd1,
    ST_CLIMB = 2'd2
  } bud_state_e;
endpackage

// File: rtl/buddy_node_store.sv
// Tree of per-node largest-free values and granted flags.
// Node n (heap order, root = 1) sits at depth clog2(n+1)-1 and covers order K-depth.
module buddy_node_store #(
  parameter int K  = 4,
  parameter int NW = K + 1,
  parameter int VW = $clog2(K + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [NW-1:0] waddr,
  input  logic [VW-1:0] wval,
  input  logic          walc,
  input  logic [NW-1:0] ra_addr,
  input  logic [NW-1:0] rb_addr,
  input  logic [NW-1:0] rc_addr,
  output logic [VW-1:0] ra_val,
  output logic [VW-1:0] rb_val,
  output logic          rc_alc,
  output logic [VW-1:0] root_val
);
  localparam int NODES = 2 ** (K + 1);

  logic [VW-1:0] val_q [NODES];
  logic          alc_q [NODES];

  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam int DEPTH = $clog2(n + 1) - 1;
    localparam logic [VW-1:0] INIT = (n == 0) ? '0 : VW'(K - DEPTH + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q[n] <= INIT;
        alc_q[n] <= 1'b0;
      end else if (we && (waddr == NW'(n))) begin
        val_q[n] <= wval;
        alc_q[n] <= walc;
      end
    end
  end

  assign ra_val   = val_q[ra_addr];
  assign rb_val   = val_q[rb_addr];
  assign rc_alc   = alc_q[rc_addr];
  assign root_val = val_q[1];
endmodule

// File: rtl/buddy_merge.sv
// Parent value from its two children: fuse when both halves are wholly free.
module buddy_merge #(
  parameter int VW = 3
) (
  input  logic [VW-1:0] lval,
  input  logic [VW-1:0] rval,
  input  logic [VW-1:0] corder,
  output logic [VW-1:0] pval
);
  logic [VW-1:0] whole;
  assign whole = corder + VW'(1);
  always_comb begin
    if (lval == whole && rval == whole) pval = corder + VW'(2);
    else if (lval > rval)               pval = lval;
    else                                pval = rval;
  end
endmodule

// File: rtl/buddy_locate.sv
// Maps a base/order pair to its tree node and checks its legality.
module buddy_locate #(
  parameter int K  = 4,
  parameter int NW = K + 1,
  parameter int VW = $clog2(K + 2)
) (
  input  logic [VW-1:0] order,
  input  logic [K-1:0]  base,
  output logic [NW-1:0] node,
  output logic          legal
);
  int sh;
  int ord_i;
  int base_i;
  always_comb begin
    node   = NW'(1);
    legal  = 1'b0;
    sh     = 0;
    ord_i  = int'(order);
    base_i = int'(base);
    if (ord_i <= K) begin
      sh    = K - ord_i;
      node  = NW'((1 << sh) | (base_i >> ord_i));
      legal = ((base_i & ((1 << ord_i) - 1)) == 0);
    end
  end
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc #(
  parameter  int K  = 4,
  localparam int OW = $clog2(K + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_free,
  input  logic [OW-1:0] req_order,
  input  logic [K-1:0]  req_base,
  output logic          rsp_valid,
  output logic          rsp_fail,
  output logic          rsp_err,
  output logic [K-1:0]  rsp_base
);
  import buddy_pkg::*;
  localparam int NW = K + 1;
  localparam logic [OW-1:0] KTOP = OW'(K);

  bud_state_e    state;
  logic [NW-1:0] cur;
  logic [OW-1:0] lvl, tgt;
  logic [K-1:0]  base_acc;

  logic          we, walc, rc_alc, loc_ok, accept;
  logic [NW-1:0] waddr, ra_addr, rb_addr, loc_node;
  logic [OW-1:0] wval, ra_val, rb_val, root_val, merged;

  buddy_node_store #(.K(K), .NW(NW), .VW(OW)) u_store (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wval(wval), .walc(walc),
    .ra_addr(ra_addr), .rb_addr(rb_addr), .rc_addr(loc_node),
    .ra_val(ra_val), .rb_val(rb_val), .rc_alc(rc_alc), .root_val(root_val)
  );

  buddy_merge #(.VW(OW)) u_merge (
    .lval(ra_val), .rval(rb_val), .corder(lvl), .pval(merged)
  );

  buddy_locate #(.K(K), .NW(NW), .VW(OW)) u_locate (
    .order(req_order), .base(req_base), .node(loc_node), .legal(loc_ok)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ra_addr   = (state == ST_DESC) ? (cur << 1) : {cur[NW-1:1], 1'b0};
  assign rb_addr   = {cur[NW-1:1], 1'b1};

  always_comb begin
    we    = 1'b0;
    waddr = cur;
    wval  = '0;
    walc  = 1'b0;
    case (state)
      ST_IDLE: if (accept && req_free && loc_ok && rc_alc) begin
        we    = 1'b1;
        waddr = loc_node;
        wval  = req_order + OW'(1);
      end
      ST_DESC: if (lvl == tgt) begin
        we   = 1'b1;
        walc = 1'b1;
      end
      ST_CLIMB: if (cur != NW'(1)) begin
        we    = 1'b1;
        waddr = cur >> 1;
        wval  = merged;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur       <= NW'(1);
      lvl       <= '0;
      tgt       <= '0;
      base_acc  <= '0;
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_base  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_err   <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (!req_free) begin
            if (req_order > KTOP || root_val < req_order + OW'(1)) begin
              rsp_valid <= 1'b1;
              rsp_fail  <= 1'b1;
              rsp_base  <= '0;
            end else begin
              state    <= ST_DESC;
              cur      <= NW'(1);
              lvl      <= KTOP;
              tgt      <= req_order;
              base_acc <= '0;
            end
          end else if (!loc_ok || !rc_alc) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_base  <= req_base;
          end else begin
            state    <= ST_CLIMB;
            cur      <= loc_node;
            lvl      <= req_order;
            base_acc <= req_base;
          end
        end
        ST_DESC: begin
          if (lvl == tgt) begin
            state <= ST_CLIMB;
          end else begin
            if (ra_val >= tgt + OW'(1)) begin
              cur <= cur << 1;
            end else begin
              cur      <= (cur << 1) | NW'(1);
              base_acc <= base_acc | (K'(1) << (lvl - OW'(1)));
            end
            lvl <= lvl - OW'(1);
          end
        end
        ST_CLIMB: begin
          if (cur == NW'(1)) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_base  <= base_acc;
          end else begin
            cur <= cur >> 1;
            lvl <= lvl + OW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/buddy_alloc_chk.sv
module buddy_alloc_chk #(
  parameter  int K  = 4,
  localparam int OW = $clog2(K + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_free,
  input logic [OW-1:0] req_order,
  input logic [K-1:0]  req_base,
  input logic          rsp_valid,
  input logic          rsp_fail,
  input logic          rsp_err,
  input logic [K-1:0]  rsp_base
);
  logic          busy, last_free;
  logic [OW-1:0] last_order;
  logic          aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      last_free  <= 1'b0;
      last_order <= '0;
    end else if (req_valid && req_ready) begin
      busy       <= 1'b1;
      last_free  <= req_free;
      last_order <= req_order;
    end else if (rsp_valid) begin
      busy <= 1'b0;
    end
  end

  assign aligned = ((int'(rsp_base) & ((1 << int'(last_order)) - 1)) == 0);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> busy); // R6
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready || rsp_valid)); // R6
  AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_fail && rsp_err)); // R7
  AST_GRANT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !last_free && !rsp_fail) |-> aligned); // R2
  AST_ALLOC_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !last_free) |-> !rsp_err); // R3
  AST_FREE_NO_FAIL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && last_free) |-> !rsp_fail); // R5
endmodule

bind buddy_alloc buddy_alloc_chk #(.K(K)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_free(req_free), .req_order(req_order), .req_base(req_base),
  .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_err(rsp_err),
  .rsp_base(rsp_base)
);

// File: tb/buddy_alloc_tb.sv
module buddy_alloc_tb;
  localparam int K  = 4;
  localparam int OW = $clog2(K + 2);
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_free = 1'b0;
  logic [OW-1:0] req_order = '0;
  logic [K-1:0]  req_base = '0;
  logic req_ready, rsp_valid, rsp_fail, rsp_err;
  logic [K-1:0] rsp_base;

  int nchk = 0;
  int nbad = 0;
  int cyc  = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  buddy_alloc #(.K(K)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_free(req_free), .req_order(req_order), .req_base(req_base),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_err(rsp_err),
    .rsp_base(rsp_base)
  );

  // {free, order[2:0], base[3:0], exp_fail, exp_err, exp_base[3:0]}
  typedef logic [13:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 4'd0},
    {1'b0, 3'd1, 4'd0, 1'b0, 1'b0, 4'd2},
    {1'b0, 3'd2, 4'd0, 1'b0, 1'b0, 4'd4},
    {1'b0, 3'd3, 4'd0, 1'b0, 1'b0, 4'd8},
    {1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 4'd1},
    {1'b0, 3'd0, 4'd0, 1'b1, 1'b0, 4'd0},
    {1'b1, 3'd2, 4'd4, 1'b0, 1'b0, 4'd4},
    {1'b1, 3'd2, 4'd4, 1'b0, 1'b1, 4'd4},
    {1'b1, 3'd1, 4'd0, 1'b0, 1'b1, 4'd0},
    {1'b1, 3'd1, 4'd3, 1'b0, 1'b1, 4'd3},
    {1'b1, 3'd0, 4'd0, 1'b0, 1'b0, 4'd0},
    {1'b1, 3'd0, 4'd1, 1'b0, 1'b0, 4'd1},
    {1'b0, 3'd1, 4'd0, 1'b0, 1'b0, 4'd0},
    {1'b0, 3'd2, 4'd0, 1'b0, 1'b0, 4'd4},
    {1'b1, 3'd1, 4'd2, 1'b0, 1'b0, 4'd2},
    {1'b1, 3'd1, 4'd0, 1'b0, 1'b0, 4'd0},
    {1'b1, 3'd2, 4'd4, 1'b0, 1'b0, 4'd4},
    {1'b1, 3'd3, 4'd8, 1'b0, 1'b0, 4'd8},
    {1'b0, 3'd4, 4'd0, 1'b0, 1'b0, 4'd0},
    {1'b0, 3'd0, 4'd0, 1'b1, 1'b0, 4'd0},
    {1'b1, 3'd4, 4'd0, 1'b0, 1'b0, 4'd0},
    {1'b0, 3'd5, 4'd0, 1'b1, 1'b0, 4'd0},
    {1'b1, 3'd5, 4'd0, 1'b0, 1'b1, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  task automatic do_op(input logic fr, input logic [OW-1:0] o, input logic [K-1:0] b,
                       output logic f, output logic e, output logic [K-1:0] rb);
    int waitc;
    @(negedge clk);
    req_valid = 1'b1; req_free = fr; req_order = o; req_base = b;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == rsp_valid, "R6 ready low while busy", int'(req_ready), int'(rsp_valid));
    waitc = 0;
    while (!rsp_valid && waitc < 50) begin
      @(negedge clk);
      waitc++;
    end
    chk(rsp_valid, "R6 response pulse", int'(rsp_valid), 1);
    f = rsp_fail; e = rsp_err; rb = rsp_base;
    @(negedge clk);
    chk(!rsp_valid, "R6 single pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    logic f, e;
    logic [K-1:0] rb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      do_op(v[13], v[12:10], v[9:6], f, e, rb);
      if (!v[13]) tag = v[5] ? "R3" : "R2";
      else        tag = v[4] ? "R5" : "R4";
      chk(f == v[5], {tag, " fail flag"}, int'(f), int'(v[5]));
      chk(e == v[4], {tag, " err flag"}, int'(e), int'(v[4]));
      chk(!(f && e), "R7 flags exclusive", int'({f, e}), 0);
      if (!v[13] && !v[5])
        chk(rb == v[3:0], {tag, " base"}, int'(rb), int'(v[3:0]));
    end

    // R1: reset in the middle of a descent frees everything
    do_op(1'b0, 3'd0, 4'd0, f, e, rb);
    chk(rb == 4'd0 && !f, "R2 first block", int'(rb), 0);
    @(negedge clk);
    req_valid = 1'b1; req_free = 1'b0; req_order = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 idle after mid-op reset", int'(req_ready), 1);
    do_op(1'b0, 3'd4, 4'd0, f, e, rb);
    chk(!f && rb == 4'd0, "R1 whole pool free after reset", int'(f), 0);
    finish_run();
  end

  initial begin
    wait (cyc > 20000);
    nchk++; nbad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
    finish_run();
  end
endmodule